// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block sits on the controller side of a single data rate SDRAM and issues one READ per accepted request. It then cuts the burst short once the requested number of words has arrived. A request carries a bank, a column, a word count, the burst mode (full-page or fixed length) and an auto-precharge flag. The selected CAS latency (2 or 3) is also supplied with the request. The block drives a compact command code and captures the returned DQ words behind a valid strobe.

Truncation uses the burst-terminate command. The terminate is placed CAS latency minus one cycles ahead of the cycle in which the last wanted word sits on DQ, so the terminate always lands in the slot whose index equals the word count. A fixed-length burst opened with auto precharge cannot be terminated. In that case the request is flagged, issued without a terminate, and only the wanted words are passed on. While a request is in flight, the block holds busy and refuses new work.

Slot numbering: the cycle in which `cmd_o` shows READ is slot 0. Data word w is presented on `dq_i` during slot CL+w.

Top module: `sdr_rd_trunc`

## Requirements
- R1: The cycle after a request is accepted (`req_valid_i` high while `busy_o` low), `cmd_o` shows READ (code 1) with the request's bank, column and auto-precharge bit, and `busy_o` is high.
- R2: In full-page mode, `cmd_o` shows burst terminate (code 2) in slot N, where N is the effective word count (a requested count of 0 counts as 1), for either CAS latency.
- R3: In fixed mode without auto precharge and with N below BURST_LEN, burst terminate appears in slot N.
- R4: In fixed mode with N at or above BURST_LEN, no terminate is issued and BURST_LEN words are delivered.
- R5: In fixed mode with auto precharge and N below BURST_LEN, `trunc_err_o` pulses in the READ slot, no terminate is issued, and N words are delivered.
- R6: The word on `dq_i` in slot CL+w appears on `rd_data_o` with `rd_valid_o` high in slot CL+w+1, for exactly the effective number of words. All later DQ values are ignored.
- R7: `busy_o` stays high from slot 0 through the slot holding the last valid word and drops in the next slot. Requests presented while busy are ignored, so no extra READ appears.
- R8: Every slot that is neither READ nor terminate carries NOP (code 0), and `dqm_o` stays low.
- R9: `trunc_legal_o` is high exactly when the presented request is full-page or has auto precharge clear.
- R10: While `rst_ni` is low, `cmd_o` is NOP, and `busy_o`, `rd_valid_o` and `trunc_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_bank_i | input | BANK_W | Bank address |
| req_col_i | input | COL_W | Start column |
| req_words_i | input | CNT_W | Wanted word count (0 treated as 1) |
| req_full_page_i | input | 1 | 1: full-page burst, 0: fixed BURST_LEN burst |
| req_auto_pre_i | input | 1 | Auto precharge requested on the READ |
| req_cl3_i | input | 1 | 1: CAS latency 3, 0: CAS latency 2 |
| dq_i | input | DQ_W | Data from the SDRAM |
| busy_o | output | 1 | Request in flight |
| trunc_legal_o | output | 1 | Presented request may be cut with terminate |
| trunc_err_o | output | 1 | One-cycle flag: cut requested but forbidden |
| cmd_o | output | 2 | Command: 0 NOP, 1 READ, 2 burst terminate |
| bank_o | output | BANK_W | Bank address to SDRAM |
| col_o | output | COL_W | Column address to SDRAM |
| auto_pre_o | output | 1 | Auto-precharge address bit |
| dqm_o | output | 1 | Data mask, held low |
| rd_valid_o | output | 1 | Captured word valid |
| rd_data_o | output | DQ_W | Captured word |

## Verification
The hardest case to reach is the one where the stop point and the capture window both depend on the CAS latency and on the word count. The terminate must fall in slot N while capture ends at CL+N. The memory model also keeps driving marker words after the point where a real device would stop. The bench reaches this by pairing a counting SDRAM model with requests that sweep both latencies, counts of 0, 1, BURST_LEN-1 and BURST_LEN, full-page counts well past BURST_LEN, and auto-precharge cuts. It keeps `req_valid_i` asserted with a changed column during every burst to exercise the busy lockout, and it starts each request in the first idle slot so that bursts run back to back.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_READ = 2'd1,
    CMD_BST  = 2'd2
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_rd_policy.sv
// Decides effective length, terminate use and legality of a request.
module sdr_rd_policy #(
  parameter int CNT_W     = 10,
  parameter int BURST_LEN = 8
) (
  input  logic [CNT_W-1:0] words_i,
  input  logic             full_page_i,
  input  logic             auto_pre_i,
  output logic [CNT_W-1:0] eff_words_o,
  output logic             use_bst_o,
  output logic             err_o,
  output logic             legal_o
);
  localparam logic [CNT_W-1:0] BL_C = CNT_W'(BURST_LEN);

  logic [CNT_W-1:0] req_n;
  logic             short_b;

  always_comb begin
    req_n   = (words_i == '0) ? CNT_W'(1) : words_i;
    short_b = req_n < BL_C;
    legal_o = full_page_i | ~auto_pre_i;
    if (full_page_i) begin
      eff_words_o = req_n;
      use_bst_o   = 1'b1;
      err_o       = 1'b0;
    end else begin
      eff_words_o = short_b ? req_n : BL_C;
      use_bst_o   = short_b & ~auto_pre_i;
      err_o       = short_b & auto_pre_i;
    end
  end
endmodule

// File: rtl/sdr_rd_seq.sv
// Slot counter and command bus driver.
module sdr_rd_seq
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int CNT_W  = 10,
  localparam int SLOT_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              auto_pre_i,
  input  logic              cl3_i,
  input  logic [CNT_W-1:0]  eff_words_i,
  input  logic              use_bst_i,
  input  logic              err_i,
  output sdr_cmd_e          cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              auto_pre_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              cl3_o,
  output logic [CNT_W-1:0]  eff_o
);
  logic              bst_q;
  logic [SLOT_W-1:0] cl_w;
  logic [SLOT_W-1:0] end_slot;
  logic [SLOT_W-1:0] slot_nx;

  always_comb begin
    cl_w     = cl3_o ? SLOT_W'(3) : SLOT_W'(2);
    end_slot = cl_w + SLOT_W'(eff_o);
    slot_nx  = slot_o + SLOT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      err_o      <= 1'b0;
      slot_o     <= '0;
      bst_q      <= 1'b0;
      cl3_o      <= 1'b0;
      eff_o      <= '0;
      cmd_o      <= CMD_NOP;
      bank_o     <= '0;
      col_o      <= '0;
      auto_pre_o <= 1'b0;
    end else if (start_i) begin
      busy_o     <= 1'b1;
      err_o      <= err_i;
      slot_o     <= '0;
      bst_q      <= use_bst_i;
      cl3_o      <= cl3_i;
      eff_o      <= eff_words_i;
      cmd_o      <= CMD_READ;
      bank_o     <= bank_i;
      col_o      <= col_i;
      auto_pre_o <= auto_pre_i;
    end else begin
      err_o <= 1'b0;
      if (busy_o) begin
        slot_o <= slot_nx;
        // terminate in slot N puts it CL-1 ahead of word N-1 at slot CL+N-1
        cmd_o  <= (bst_q && slot_nx == SLOT_W'(eff_o)) ? CMD_BST : CMD_NOP;
        if (slot_o == end_slot) busy_o <= 1'b0;
      end else begin
        cmd_o <= CMD_NOP;
      end
    end
  end
endmodule

// File: rtl/sdr_rd_capture.sv
// Registers DQ words inside the wanted window.
module sdr_rd_capture #(
  parameter int DQ_W  = 16,
  parameter int CNT_W = 10,
  localparam int SLOT_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              cl3_i,
  input  logic [CNT_W-1:0]  eff_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              valid_o,
  output logic [DQ_W-1:0]   data_o
);
  logic [SLOT_W-1:0] first_s;
  logic [SLOT_W-1:0] stop_s;
  logic              in_win;

  always_comb begin
    first_s = cl3_i ? SLOT_W'(3) : SLOT_W'(2);
    stop_s  = first_s + SLOT_W'(eff_i);
    in_win  = busy_i && (slot_i >= first_s) && (slot_i < stop_s);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= in_win;
      if (in_win) data_o <= dq_i;
    end
  end
endmodule

// File: rtl/sdr_rd_trunc.sv
module sdr_rd_trunc
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 9,
  parameter int DQ_W      = 16,
  parameter int CNT_W     = 10,
  parameter int BURST_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [CNT_W-1:0]  req_words_i,
  input  logic              req_full_page_i,
  input  logic              req_auto_pre_i,
  input  logic              req_cl3_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              busy_o,
  output logic              trunc_legal_o,
  output logic              trunc_err_o,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              auto_pre_o,
  output logic              dqm_o,
  output logic              rd_valid_o,
  output logic [DQ_W-1:0]   rd_data_o
);
  localparam int SLOT_W = CNT_W + 2;

  logic [CNT_W-1:0]  eff_words;
  logic              use_bst;
  logic              pol_err;
  logic              start;
  sdr_cmd_e          cmd_q;
  logic [SLOT_W-1:0] slot;
  logic              cl3_q;
  logic [CNT_W-1:0]  eff_q;

  assign start = req_valid_i & ~busy_o;
  assign cmd_o = cmd_q;
  assign dqm_o = 1'b0;

  sdr_rd_policy #(.CNT_W(CNT_W), .BURST_LEN(BURST_LEN)) u_policy (
    .words_i     (req_words_i),
    .full_page_i (req_full_page_i),
    .auto_pre_i  (req_auto_pre_i),
    .eff_words_o (eff_words),
    .use_bst_o   (use_bst),
    .err_o       (pol_err),
    .legal_o     (trunc_legal_o)
  );

  sdr_rd_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .bank_i      (req_bank_i),
    .col_i       (req_col_i),
    .auto_pre_i  (req_auto_pre_i),
    .cl3_i       (req_cl3_i),
    .eff_words_i (eff_words),
    .use_bst_i   (use_bst),
    .err_i       (pol_err),
    .cmd_o       (cmd_q),
    .bank_o      (bank_o),
    .col_o       (col_o),
    .auto_pre_o  (auto_pre_o),
    .busy_o      (busy_o),
    .err_o       (trunc_err_o),
    .slot_o      (slot),
    .cl3_o       (cl3_q),
    .eff_o       (eff_q)
  );

  sdr_rd_capture #(.DQ_W(DQ_W), .CNT_W(CNT_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy_o),
    .slot_i  (slot),
    .cl3_i   (cl3_q),
    .eff_i   (eff_q),
    .dq_i    (dq_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/sdr_rd_trunc_chk.sv
module sdr_rd_trunc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       busy_o,
  input logic       trunc_err_o,
  input logic [1:0] cmd_o,
  input logic       rd_valid_o
);
  // R1
  read_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 2'd1 |-> $past(req_valid_i) && busy_o);

  // R7
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 2'd1 |-> !$past(busy_o));

  // R2
  bst_in_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 2'd2 |-> busy_o);

  // R5
  err_with_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_err_o |-> cmd_o == 2'd1);

  // R6
  valid_in_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> busy_o);

  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(rd_valid_o));
endmodule

bind sdr_rd_trunc sdr_rd_trunc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .trunc_err_o (trunc_err_o),
  .cmd_o       (cmd_o),
  .rd_valid_o  (rd_valid_o)
);

// File: tb/sdr_rd_trunc_tb_top.sv
`timescale 1ns/1ps
module sdr_rd_trunc_tb_top;
  localparam int BANK_W = 2;
  localparam int COL_W  = 9;
  localparam int DQ_W   = 16;
  localparam int CNT_W  = 10;
  localparam int BL     = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [BANK_W-1:0] req_bank_i = '0;
  logic [COL_W-1:0]  req_col_i = '0;
  logic [CNT_W-1:0]  req_words_i = '0;
  logic              req_full_page_i = 1'b0;
  logic              req_auto_pre_i = 1'b0;
  logic              req_cl3_i = 1'b0;
  logic [DQ_W-1:0]   dq_i = '0;
  logic              busy_o, trunc_legal_o, trunc_err_o, auto_pre_o, dqm_o, rd_valid_o;
  logic [1:0]        cmd_o;
  logic [BANK_W-1:0] bank_o;
  logic [COL_W-1:0]  col_o;
  logic [DQ_W-1:0]   rd_data_o;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sdr_rd_trunc #(.BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W), .CNT_W(CNT_W),
                 .BURST_LEN(BL)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_of(int n, bit fp);
    int r = (n == 0) ? 1 : n;
    if (!fp && r > BL) r = BL;
    return r;
  endfunction

  function automatic bit bst_of(int n, bit fp, bit ap);
    int r = (n == 0) ? 1 : n;
    return fp || (!ap && r < BL);
  endfunction

  function automatic logic [DQ_W-1:0] pat(int col, int w);
    return DQ_W'((col * 37 + w * 11 + 16'h1357) & 16'hFFFF);
  endfunction

  // SDRAM model: word w in slot cl+w until the device stops
  function automatic logic [DQ_W-1:0] mem(int s, int cl, int col, int eff, bit bst, bit fp);
    int w = s - cl;
    int lim = bst ? eff : (fp ? 1 << 20 : BL);
    if (w < 0 || w >= lim) return DQ_W'(16'hBAD0 ^ s);
    return pat(col, w);
  endfunction

  task automatic run_txn(int bank, int col, int n, bit fp, bit ap, bit cl3);
    int cl  = cl3 ? 3 : 2;
    int eff = eff_of(n, fp);
    bit bst = bst_of(n, fp, ap);
    bit err = !fp && ap && (((n == 0) ? 1 : n) < BL);
    int exp_cmd;
    while (busy_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_bank_i = BANK_W'(bank);
    req_col_i = COL_W'(col);
    req_words_i = CNT_W'(n);
    req_full_page_i = fp;
    req_auto_pre_i = ap;
    req_cl3_i = cl3;
    #1;
    chk(trunc_legal_o == (fp || !ap), "R9 legal", trunc_legal_o, fp || !ap);
    @(negedge clk_i);
    chk(cmd_o == 2'd1, "R1 read cmd", cmd_o, 1);
    chk(bank_o == BANK_W'(bank) && col_o == COL_W'(col) && auto_pre_o == ap,
        "R1 address", {bank_o, col_o, auto_pre_o}, {BANK_W'(bank), COL_W'(col), ap});
    chk(busy_o, "R1 busy", busy_o, 1);
    chk(trunc_err_o == err, "R5 err flag", trunc_err_o, err);
    // keep a changed request asserted while busy
    req_col_i = COL_W'(col + 5);
    dq_i = mem(0, cl, col, eff, bst, fp);
    for (int s = 1; s <= cl + eff + 1; s++) begin
      @(negedge clk_i);
      exp_cmd = (bst && s == eff) ? 2 : 0;
      chk(cmd_o == 2'(exp_cmd),
          fp ? "R2 cmd" : (bst ? "R3 cmd" : (err ? "R5 cmd" : "R4 cmd")), cmd_o, exp_cmd);
      chk(dqm_o == 1'b0, "R8 dqm", dqm_o, 0);
      chk(trunc_err_o == 1'b0, "R5 err pulse", trunc_err_o, 0);
      chk(busy_o == (s <= cl + eff), "R7 busy", busy_o, s <= cl + eff);
      if (s >= cl + 1 && s <= cl + eff) begin
        chk(rd_valid_o, "R6 valid", rd_valid_o, 1);
        chk(rd_data_o == pat(col, s - cl - 1), "R6 data", rd_data_o, pat(col, s - cl - 1));
      end else begin
        chk(!rd_valid_o, "R6 no extra valid", rd_valid_o, 0);
      end
      if (s == cl + eff) req_valid_i = 1'b0;
      dq_i = mem(s, cl, col, eff, bst, fp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk_i);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    // R10 reset state, with a request held during reset
    chk(cmd_o == 2'd0, "R10 cmd", cmd_o, 0);
    chk(!busy_o && !rd_valid_o && !trunc_err_o, "R10 flags",
        {busy_o, rd_valid_o, trunc_err_o}, 0);
    req_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_o == 2'd0 && !busy_o, "R8 idle nop", cmd_o, 0);

    // directed corners
    run_txn(1, 10, 0, 1'b0, 1'b0, 1'b0);   // R3 zero count
    run_txn(2, 20, 1, 1'b1, 1'b0, 1'b1);   // R2
    run_txn(3, 30, 4, 1'b1, 1'b0, 1'b0);   // R2 CL2
    run_txn(0, 40, 20, 1'b1, 1'b1, 1'b1);  // R2 long, ap ignored
    run_txn(1, 50, BL - 1, 1'b0, 1'b0, 1'b1); // R3
    run_txn(2, 60, BL, 1'b0, 1'b0, 1'b0);  // R4
    run_txn(3, 70, BL + 3, 1'b0, 1'b1, 1'b1); // R4 with ap
    run_txn(0, 80, 3, 1'b0, 1'b1, 1'b0);  // R5
    run_txn(1, 90, 1, 1'b0, 1'b1, 1'b1);  // R5
    // random
    for (int i = 0; i < 80; i++) begin
      bit fp = ($urandom % 4) == 0;
      int n  = fp ? int'($urandom_range(0, 30)) : int'($urandom_range(0, 12));
      run_txn(int'($urandom % 4), int'($urandom % 512), n, fp,
              1'($urandom % 2), 1'($urandom % 2));
    end
    @(negedge clk_i);
    chk(!busy_o && cmd_o == 2'd0, "R7 idle end", busy_o, 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule